// File: doc/BRIEF.md
# Key-Configurable Folded Cascade Filter

This block runs a chain of up to M identical FIR sections on a single shared multiply-accumulate unit. Each section has N taps, its own coefficient bank and its own input history. An accepted input sample starts a frame that always lasts N·M clock cycles. Inside the frame, the slots are handed out section by section: every tap of section j runs before any tap of section j+1. The saturated result of each section is pushed into the history of the next section and becomes that section's newest input.

A key of 2K bits chooses how many sections l (1 to M) take part in the filtering. The key is decoded combinationally and is captured together with the sample. Slots that belong to sections at or beyond l are null operations. The frame length and the output timing pattern therefore do not depend on whether the key is right. Keys that decode to no defined section count fall back to a fixed default, so every key yields output that looks like filtering.

Top module: `fold_cascade`

## Requirements
- R1: A frame lasts exactly N·M cycles. A sample is accepted when in_valid is high and the block is idle or in the last slot of a frame. At any other time in_valid and in_data are ignored, so frames can run back to back.
- R2: Slot s of a frame executes tap s mod N of section s div N. Every tap of a section completes before the next section begins.
- R3: Section j computes y = sat( sum over i of c(j,i)·h_j[i] ), where h_j[0] is the section's newest input and h_j[i] the input i frames earlier. The coefficients are c(j,i) = ((3·i + 5·j + 1) mod 7) − 3.
- R4: When l sections are selected, slots l·N through N·M−1 change neither the accumulator, the output, nor the history of any unused section. Those histories resume later from their old contents.
- R5: out_valid is high for exactly one cycle per frame: the cycle after the clock edge that ends slot l·N−1, counting slot 0 as the cycle right after the accepting edge. out_data carries the result of section l−1 and holds its value otherwise.
- R6: The key is decoded as v = key XOR 4'hA. If 1 ≤ v ≤ M, then l = v. Otherwise l = 1.
- R7: The key is sampled only on the edge that accepts a sample. Changing it during a frame does not alter that frame's section count, timing or result.
- R8: For j < l−1, the saturated result of section j is shifted into the history of section j+1 at the end of section j's last tap.
- R9: Each section result saturates to the signed DW-bit range [−2^(DW−1), 2^(DW−1)−1] instead of wrapping.
- R10: A synchronous reset clears the slot counter, the accumulator, all section histories and out_data. It deasserts out_valid and aborts any frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered this cycle |
| in_data | input | DW | Signed input sample |
| key | input | 2K | Configuration key selecting the section count |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | DW | Signed result of the last active section |

## Verification
A fault in the slot counter or the section counter shifts the out_valid strobe away from the cycle l·N after acceptance. The bench sees that within the same frame. A wrong coefficient, a history that shifts in a null slot, or a missing hand-over between sections may not change the current frame's output. It does change the value seen in the frame that first reads the corrupted history, which can be several frames later when the section count is switched up again. A decoder fault appears at once as a strobe in the wrong slot for the key applied.

// File: rtl/fold_pkg.sv
package fold_pkg;
  // Coefficient of tap i in section j; kept in one place so the datapath
  // and any model agree on the rule, not on a table.
  function automatic int tap_coef(input int j, input int i);
    return ((3 * i + 5 * j + 1) % 7) - 3;
  endfunction
endpackage

// File: rtl/fold_keydec.sv
module fold_keydec #(
  parameter int K = 2,
  parameter int M = 3,
  parameter logic [2*K-1:0] SALT = 'hA,
  parameter int DEF_L = 1,
  localparam int KW = 2 * K,
  localparam int LW = $clog2(M + 1)
) (
  input  logic [KW-1:0] key,
  output logic [LW-1:0] sections
);
  logic [KW-1:0] raw;

  always_comb begin
    raw = key ^ SALT;
    if (raw >= KW'(1) && raw <= KW'(M)) sections = raw[LW-1:0];
    else                                 sections = LW'(DEF_L);
  end

  // R6: decoded count is always a legal mode
  always_comb begin
    p_mode_range_r6: assert (sections >= LW'(1) && sections <= LW'(M));
  end
endmodule

// File: rtl/fold_sched.sv
module fold_sched #(
  parameter int N = 4,
  parameter int M = 3,
  localparam int SW = $clog2(N * M),
  localparam int OW = $clog2(N),
  localparam int LW = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [SW-1:0] slot,
  output logic [LW-1:0] sec,
  output logic [OW-1:0] op,
  output logic          op_first,
  output logic          op_last,
  output logic          slot_last
);
  assign op_first  = (op == '0);
  assign op_last   = (op == OW'(N - 1));
  assign slot_last = busy && (slot == SW'(N * M - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      slot <= '0;
      sec  <= '0;
      op   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      slot <= '0;
      sec  <= '0;
      op   <= '0;
    end else if (busy) begin
      if (slot_last) begin
        busy <= 1'b0;
        slot <= '0;
        sec  <= '0;
        op   <= '0;
      end else begin
        slot <= slot + SW'(1);
        if (op_last) begin
          op  <= '0;
          sec <= sec + LW'(1);
        end else begin
          op <= op + OW'(1);
        end
      end
    end
  end

  // R1: slots advance one per cycle inside a frame
  p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
    busy && !slot_last && !start |=> busy && (slot == $past(slot) + SW'(1)));
  // R1: frame closes after its last slot unless a new sample arrives
  p_frame_end_r1: assert property (@(posedge clk) disable iff (rst)
    slot_last && !start |=> !busy);
  // R2: a section hands over only after its last tap
  p_contig_r2: assert property (@(posedge clk) disable iff (rst)
    busy && op_last && !slot_last && !start |=> (sec == $past(sec) + LW'(1)) && op_first);
endmodule

// File: rtl/fold_mac.sv
module fold_mac #(
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 clr,
  input  logic signed [DW-1:0] a,
  input  logic signed [CW-1:0] b,
  output logic signed [AW-1:0] acc_q,
  output logic signed [AW-1:0] acc_nx
);
  logic signed [AW-1:0] prod;

  assign prod   = AW'(a) * AW'(b);
  assign acc_nx = (clr ? AW'(0) : acc_q) + prod;

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_nx;
  end

  // R4: an idle unit keeps its partial sum
  p_acc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/fold_cascade.sv
module fold_cascade #(
  parameter int N = 4,
  parameter int M = 3,
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int K = 2,
  parameter logic [2*K-1:0] SALT = 'hA,
  parameter int DEF_L = 1,
  localparam int KW = 2 * K,
  localparam int LW = $clog2(M + 1),
  localparam int SW = $clog2(N * M),
  localparam int OW = $clog2(N),
  localparam int JW = (M > 1) ? $clog2(M) : 1,
  localparam int AW = DW + CW + $clog2(N) + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic [KW-1:0]        key,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  import fold_pkg::*;

  localparam logic signed [AW-1:0] HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] LO = ~HI;

  function automatic logic signed [DW-1:0] clamp_dw(input logic signed [AW-1:0] v);
    if (v > HI)      return HI[DW-1:0];
    else if (v < LO) return LO[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  // schedule and mode
  logic          busy, op_first, op_last, slot_last;
  logic [SW-1:0] slot;
  logic [LW-1:0] sec, dec_sections, mode_q;
  logic [OW-1:0] op;
  logic [JW-1:0] sec_ix;
  logic          start, op_live, null_slot, push, finish;

  assign start = in_valid && (!busy || slot_last);

  fold_keydec #(.K(K), .M(M), .SALT(SALT), .DEF_L(DEF_L)) u_dec (
    .key(key), .sections(dec_sections));

  fold_sched #(.N(N), .M(M)) u_sched (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .slot(slot),
    .sec(sec), .op(op), .op_first(op_first), .op_last(op_last),
    .slot_last(slot_last));

  always_ff @(posedge clk) begin
    if (rst)        mode_q <= LW'(DEF_L);
    else if (start) mode_q <= dec_sections;
  end

  assign sec_ix    = sec[JW-1:0];
  assign op_live   = busy && (sec < mode_q);
  assign null_slot = busy && !op_live;
  assign push      = op_live && op_last && (sec + LW'(1) <  mode_q);
  assign finish    = op_live && op_last && (sec + LW'(1) == mode_q);

  // coefficient banks computed from the rule
  logic signed [CW-1:0] coef_rom [M][N];
  for (genvar gj = 0; gj < M; gj++) begin : g_bank
    for (genvar gi = 0; gi < N; gi++) begin : g_tap
      assign coef_rom[gj][gi] = CW'(tap_coef(gj, gi));
    end
  end

  // per-section input histories
  logic signed [DW-1:0] hist [M][N];
  logic signed [AW-1:0] acc_q, acc_nx;
  logic signed [DW-1:0] sec_res, opnd;
  logic signed [CW-1:0] cur_coef;

  assign opnd     = hist[sec_ix][op];
  assign cur_coef = coef_rom[sec_ix][op];
  assign sec_res  = clamp_dw(acc_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < M; j++)
        for (int i = 0; i < N; i++) hist[j][i] <= '0;
    end else begin
      if (start) begin
        for (int i = N - 1; i > 0; i--) hist[0][i] <= hist[0][i-1];
        hist[0][0] <= in_data;
      end
      for (int j = 1; j < M; j++) begin
        if (push && (int'(sec_ix) == j - 1)) begin
          for (int i = N - 1; i > 0; i--) hist[j][i] <= hist[j][i-1];
          hist[j][0] <= sec_res;
        end
      end
    end
  end

  fold_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
    .clk(clk), .rst(rst), .en(op_live), .clr(op_first),
    .a(opnd), .b(cur_coef), .acc_q(acc_q), .acc_nx(acc_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= finish;
      if (finish) out_data <= sec_res;
    end
  end

  // R4: null slots leave output and partial sum untouched
  p_null_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    null_slot |=> !out_valid && $stable(out_data) && $stable(acc_q));
  // R5: strobe is a single cycle
  p_one_valid_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R5: result lands in the last slot of section l-1
  p_valid_slot_r5: assert property (@(posedge clk) disable iff (rst)
    finish |-> (int'(slot) + 1 == int'(mode_q) * N));
  // R7: mode is frozen for the whole frame
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    busy && !start |=> $stable(mode_q));
  // R10: reset leaves the block idle and cleared
  p_reset_r10: assert property (@(posedge clk)
    rst |=> !out_valid && !busy && (acc_q == '0) && (out_data == '0));
endmodule

// File: tb/sim_fold_cascade.sv
`timescale 1ns/1ps
module sim_fold_cascade;
  localparam int N = 4;
  localparam int M = 3;
  localparam int DW = 16;
  localparam int NM = N * M;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic [3:0] key = 4'h0;
  logic out_valid;
  logic signed [DW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  longint mh [M][N];

  always #2 clk = ~clk;

  fold_cascade #(.N(N), .M(M), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .key(key), .out_valid(out_valid), .out_data(out_data));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint cf(int j, int i);
    int t = (i * 3 + j * 5 + 1) % 7;
    return longint'(t) - 3;
  endfunction

  function automatic longint clip(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [3:0] key_for(int l);
    return 4'(l) ^ 4'hA;
  endfunction

  // reference: advance the histories of l sections by one sample
  function automatic longint model(longint s, int l);
    longint y = 0;
    longint x = s;
    for (int j = 0; j < l; j++) begin
      longint sum = 0;
      for (int i = N - 1; i > 0; i--) mh[j][i] = mh[j][i-1];
      mh[j][0] = x;
      for (int i = 0; i < N; i++) sum += cf(j, i) * mh[j][i];
      y = clip(sum);
      x = y;
    end
    return y;
  endfunction

  function automatic void model_clear();
    for (int j = 0; j < M; j++)
      for (int i = 0; i < N; i++) mh[j][i] = 0;
  endfunction

  // one frame: drive at a negedge, watch every slot, end at a negedge
  task automatic frame(input longint s, input logic [3:0] k, input int l,
                       input bit kchg, input string tag);
    longint exp;
    bit stray = 1'b0;
    bit seen = 1'b0;
    in_data = DW'(s);
    key = k;
    in_valid = 1'b1;
    exp = model(s, l);
    for (int c = 1; c <= NM + 1; c++) begin
      @(negedge clk);
      if (c == 1) in_valid = 1'b0;
      if (c == 2 && kchg) key = ~k;
      if (c == l * N + 1) begin
        seen = out_valid;
        chk(out_data == exp, {tag, " data"}, out_data, exp);
      end else if (out_valid !== 1'b0) begin
        stray = 1'b1;
      end
    end
    chk(seen, {tag, " R5 strobe in slot l*N"}, seen, 1);
    chk(!stray, {tag, " R4 no strobe elsewhere"}, stray, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset valid", out_valid, 0);
    chk(out_data == 0, "R10 reset data", out_data, 0);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
  endtask

  task automatic t_modes();
    frame(100, key_for(1), 1, 0, "R3 l=1");
    frame(-50, key_for(1), 1, 0, "R3 l=1 second");
    frame(7, key_for(2), 2, 0, "R8 l=2");
    frame(300, key_for(3), 3, 0, "R2 l=3 full");
    frame(-12, key_for(1), 1, 0, "R4 l=1 after full");
    frame(45, key_for(3), 3, 0, "R4 unused histories kept");
    frame(-9, key_for(2), 2, 0, "R8 l=2 again");
  endtask

  task automatic t_bad_keys();
    frame(21, 4'hA, 1, 0, "R6 key raw 0");
    frame(-33, 4'hF, 1, 0, "R6 key raw 5");
    frame(5, 4'h2, 1, 0, "R6 key raw 8");
  endtask

  task automatic t_key_mid();
    frame(64, key_for(3), 3, 1, "R7 key change l=3");
    frame(-70, key_for(1), 1, 1, "R7 key change l=1");
  endtask

  // in_valid held high across two frames, data changed mid-frame
  task automatic t_back_to_back();
    longint ea, eb;
    bit stray = 1'b0;
    in_data = 16'sd40;
    key = key_for(2);
    in_valid = 1'b1;
    ea = model(40, 2);
    eb = model(-25, 2);
    for (int c = 1; c <= 2 * NM + 1; c++) begin
      @(negedge clk);
      if (c == 2) in_data = -16'sd25;
      if (c == NM + 1) in_valid = 1'b0;
      if (c == 2 * N + 1) begin
        chk(out_valid == 1'b1, "R1 first frame strobe", out_valid, 1);
        chk(out_data == ea, "R1 mid-frame in_valid ignored", out_data, ea);
      end else if (c == NM + 2 * N + 1) begin
        chk(out_valid == 1'b1, "R1 back-to-back strobe", out_valid, 1);
        chk(out_data == eb, "R1 back-to-back data", out_data, eb);
      end else if (out_valid !== 1'b0) begin
        stray = 1'b1;
      end
    end
    chk(!stray, "R1 exactly one strobe per frame", stray, 0);
  endtask

  task automatic t_saturate();
    frame(32767, key_for(1), 1, 0, "R9 negative clip");
    frame(-32768, key_for(1), 1, 0, "R9 positive clip");
    frame(32767, key_for(3), 3, 0, "R9 clip through cascade");
  endtask

  task automatic t_reset_mid();
    bit stray = 1'b0;
    in_data = 16'sd999;
    key = key_for(3);
    in_valid = 1'b1;
    for (int c = 1; c <= NM + 2; c++) begin
      @(negedge clk);
      if (c == 1) in_valid = 1'b0;
      if (c == 3) rst = 1'b1;
      if (c == 5) rst = 1'b0;
      if (out_valid !== 1'b0) stray = 1'b1;
    end
    chk(!stray, "R10 aborted frame gives no strobe", stray, 0);
    chk(out_data == 0, "R10 data cleared", out_data, 0);
    model_clear();
    frame(11, key_for(3), 3, 0, "R10 histories cleared");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_modes();
    t_bad_keys();
    t_key_mid();
    t_back_to_back();
    t_saturate();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule